// File: doc/BRIEF.md
# Interrupt Activation Router

This block sits between the peripheral interrupt lines and three consumers: the DMA channels, a descriptor-based data-transfer controller (DTC), and the CPU interrupt path. Each DMA channel has a 4-bit field that picks one source and a claim bit. A claimed source feeds only that channel. Each unclaimed source is sent either to the DTC or to the CPU, depending on a per-source enable bit.

DTC requests are arbitrated in a fixed order, and the lowest source index wins. The winner is shown as a one-hot vector with a valid flag. It stays on the outputs until the DTC reports that the transfer is done. With that report the DTC gives two flags: the counter reached zero, and interrupt-after-transfer. If either flag is set, the source's enable bit is cleared and a CPU interrupt is raised for that source. If neither is set, a one-cycle clear pulse goes back to the source. CPU requests are levels that stay set until the CPU-side clear for that source.

Top module: `irq_route_top`

## Requirements
- R1: A synchronous active-high reset clears all enable bits, claim bits, channel selects, CPU requests, clear pulses and any pending DTC activation. After reset, every outputs reads 0, and a request from any source goes to the CPU path.
- R2: `dmaReq[c]` is high in the same cycle as `srcReq[s]` when channel c has its claim bit set and its 4-bit select field holds s.
- R3: A source claimed by any channel never raises `dtcActValid` for itself and never sets its bit of `cpuIrq`, whatever its enable bit holds.
- R4: An unclaimed requesting source with enable bit 0 sets its `cpuIrq` bit on the next clock edge. With enable bit 1 it becomes a DTC candidate.
- R5: When idle with at least one candidate, the block raises `dtcActValid` on the next edge, with `dtcActVec` one-hot on the chosen source. Both are held unchanged until `dtcDone` is sampled high.
- R6: Among the candidates, the lowest source index is chosen. Requests that arrive while a transfer is in progress wait for the next arbitration.
- R7: When `dtcDone` arrives with `dtcZeroCount` or `dtcIntSel` high, the enable bit of the granted source is cleared and its `cpuIrq` bit is set on the next edge. No clear pulse is produced.
- R8: When `dtcDone` arrives with both flags low, `srcClr` carries a pulse of exactly one cycle on the granted source's bit, on the next edge. The enable bit stays set.
- R9: While a source's DTC transfer is in progress, its `cpuIrq` bit does not rise.
- R10: A `cpuIrq` bit stays high until its `cpuClr` bit is high at an edge. A new set in the same cycle as a clear wins.
- R11: `cfgWrEn` loads the whole enable vector from `cfgWrData` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcReq | input | 16 | Peripheral interrupt request levels |
| cfgWrEn | input | 1 | Write strobe for the DTC enable vector |
| cfgWrData | input | 16 | New DTC enable vector (1 = DTC, 0 = CPU) |
| chWrEn | input | 2 | Per-channel write strobe for select and claim |
| chWrSel | input | 4 | Source index written to the channel select field |
| chWrClaim | input | 1 | Claim bit written to the channel |
| dtcDone | input | 1 | DTC transfer-complete acknowledge |
| dtcZeroCount | input | 1 | Transfer counter reached zero (valid with dtcDone) |
| dtcIntSel | input | 1 | Interrupt-after-transfer select (valid with dtcDone) |
| cpuClr | input | 16 | CPU-side clear of interrupt request bits |
| dmaReq | output | 2 | DMA channel activation requests |
| dtcActValid | output | 1 | DTC activation pending |
| dtcActVec | output | 16 | One-hot source of the pending DTC activation |
| cpuIrq | output | 16 | CPU interrupt request levels |
| srcClr | output | 16 | One-cycle clear pulses to the sources |

## Verification
The assertions assume that the channel configuration and the enable vector for a source are not rewritten while that source's DTC transfer is in progress. They also assume that `dtcDone` is a single-cycle pulse that comes only while `dtcActValid` is high. The directed tasks follow both rules: every configuration write happens while the router is idle or concerns other sources, and each done pulse is driven for one cycle after the bench has seen the activation. The bench drops a source's request in the cycle it observes that source's clear pulse, in the same way a peripheral would.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef struct packed {
    logic grantLoad;
    logic finishClr;
    logic handoff;
  } ctrlStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } routeState_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        anyCand,
  input  logic        dtcDone,
  input  logic        dtcZeroCount,
  input  logic        dtcIntSel,
  output logic        busy,
  output ctrlStrobe_t strobe
);
  routeState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (anyCand) begin
        strobe.grantLoad = 1'b1;
        stateNext = ST_BUSY;
      end
      ST_BUSY: if (dtcDone) begin
        strobe.handoff   = dtcZeroCount | dtcIntSel;
        strobe.finishClr = ~(dtcZeroCount | dtcIntSel);
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state == ST_BUSY);

  // R5: once a grant is loaded, the block reports busy on the following cycle
  a_r5_grant_busy: assert property (@(posedge clk) disable iff (rst)
    strobe.grantLoad |=> busy);

  // R7/R8: a completion always returns the router to idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    (busy && dtcDone) |=> !busy);
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CH  = 2,
  localparam int SELW   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] cpuClr,
  input  logic               cfgWrEn,
  input  logic [NUM_SRC-1:0] cfgWrData,
  input  logic [NUM_CH-1:0]  chWrEn,
  input  logic [SELW-1:0]    chWrSel,
  input  logic               chWrClaim,
  input  ctrlStrobe_t        strobe,
  input  logic               busy,
  output logic               anyCand,
  output logic [NUM_CH-1:0]  dmaReq,
  output logic [NUM_SRC-1:0] dtcActVec,
  output logic [NUM_SRC-1:0] cpuIrq,
  output logic [NUM_SRC-1:0] srcClr
);
  logic [NUM_SRC-1:0] dtcEn;
  logic [SELW-1:0]    chSel [NUM_CH];
  logic [NUM_CH-1:0]  chClaim;
  logic [NUM_SRC-1:0] claimedVec;
  logic [NUM_SRC-1:0] dtcCand;
  logic [NUM_SRC-1:0] pickVec;
  logic [NUM_SRC-1:0] grantQ;
  logic [NUM_SRC-1:0] handoffVec;
  logic [NUM_SRC-1:0] cpuSet;

  // Channel configuration and DMA activation, one slice per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        chSel[c]   <= '0;
        chClaim[c] <= 1'b0;
      end else if (chWrEn[c]) begin
        chSel[c]   <= chWrSel;
        chClaim[c] <= chWrClaim;
      end
    end
    assign dmaReq[c] = chClaim[c] & srcReq[chSel[c]];
  end

  always_comb begin
    claimedVec = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (chClaim[c]) claimedVec[chSel[c]] = 1'b1;
  end

  // A source whose clear pulse is in flight is not re-arbitrated
  assign dtcCand = srcReq & dtcEn & ~claimedVec & ~srcClr;
  assign anyCand = |dtcCand;

  // Fixed priority: the lowest index is written last and wins
  always_comb begin
    pickVec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (dtcCand[i]) begin
        pickVec    = '0;
        pickVec[i] = 1'b1;
      end
  end

  assign handoffVec = strobe.handoff ? grantQ : '0;
  assign cpuSet     = (srcReq & ~dtcEn & ~claimedVec) | handoffVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      dtcEn  <= '0;
      grantQ <= '0;
      cpuIrq <= '0;
      srcClr <= '0;
    end else begin
      dtcEn  <= (cfgWrEn ? cfgWrData : dtcEn) & ~handoffVec;
      if (strobe.grantLoad) grantQ <= pickVec;
      cpuIrq <= (cpuIrq & ~cpuClr) | cpuSet;
      srcClr <= strobe.finishClr ? grantQ : '0;
    end
  end

  assign dtcActVec = busy ? grantQ : '0;

  // R6: the grant has no candidate of lower index than itself
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (rst)
    strobe.grantLoad |=> (($past(dtcCand) & (grantQ - 1'b1)) == '0));

  // R5: the activation is one-hot and held until completion
  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(dtcActVec) == 1));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !strobe.handoff && !strobe.finishClr) |=> (busy && $stable(dtcActVec)));

  // R3: a claimed source never gets a new CPU request
  a_r3_claim_no_cpu: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cpuIrq & ~$past(cpuIrq) & $past(claimedVec)) == '0));

  // R7: a hand-off raises the CPU request and drops the enable bit
  a_r7_handoff: assert property (@(posedge clk) disable iff (rst)
    strobe.handoff |=> (((cpuIrq & $past(grantQ)) != '0) && ((dtcEn & $past(grantQ)) == '0)));

  // R8: the clear pulse is one-hot and lasts a single cycle
  a_r8_clr_pulse: assert property (@(posedge clk) disable iff (rst)
    (srcClr != '0) |-> (($countones(srcClr) == 1) ##1 (srcClr == '0)));

  // R9: no CPU request rises for the source being transferred
  a_r9_dtc_first: assert property (@(posedge clk) disable iff (rst)
    (busy && !strobe.handoff) |=> ((cpuIrq & ~$past(cpuIrq) & $past(grantQ)) == '0));
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CH  = 2,
  localparam int SELW   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               cfgWrEn,
  input  logic [NUM_SRC-1:0] cfgWrData,
  input  logic [NUM_CH-1:0]  chWrEn,
  input  logic [SELW-1:0]    chWrSel,
  input  logic               chWrClaim,
  input  logic               dtcDone,
  input  logic               dtcZeroCount,
  input  logic               dtcIntSel,
  input  logic [NUM_SRC-1:0] cpuClr,
  output logic [NUM_CH-1:0]  dmaReq,
  output logic               dtcActValid,
  output logic [NUM_SRC-1:0] dtcActVec,
  output logic [NUM_SRC-1:0] cpuIrq,
  output logic [NUM_SRC-1:0] srcClr
);
  ctrlStrobe_t strobe;
  logic        busy;
  logic        anyCand;

  irq_route_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .anyCand      (anyCand),
    .dtcDone      (dtcDone),
    .dtcZeroCount (dtcZeroCount),
    .dtcIntSel    (dtcIntSel),
    .busy         (busy),
    .strobe       (strobe)
  );

  irq_route_dp #(.NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .srcReq    (srcReq),
    .cpuClr    (cpuClr),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .chWrEn    (chWrEn),
    .chWrSel   (chWrSel),
    .chWrClaim (chWrClaim),
    .strobe    (strobe),
    .busy      (busy),
    .anyCand   (anyCand),
    .dmaReq    (dmaReq),
    .dtcActVec (dtcActVec),
    .cpuIrq    (cpuIrq),
    .srcClr    (srcClr)
  );

  assign dtcActValid = busy;

  // R1: outputs are quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!dtcActValid && (cpuIrq == '0) && (srcClr == '0) && (dmaReq == '0)));
endmodule

// File: tb/tb_irq_route_top.sv
module tb_irq_route_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] srcReq = '0;
  logic          cfgWrEn = 1'b0;
  logic [NS-1:0] cfgWrData = '0;
  logic [NC-1:0] chWrEn = '0;
  logic [3:0]    chWrSel = '0;
  logic          chWrClaim = 1'b0;
  logic          dtcDone = 1'b0;
  logic          dtcZeroCount = 1'b0;
  logic          dtcIntSel = 1'b0;
  logic [NS-1:0] cpuClr = '0;
  logic [NC-1:0] dmaReq;
  logic          dtcActValid;
  logic [NS-1:0] dtcActVec;
  logic [NS-1:0] cpuIrq;
  logic [NS-1:0] srcClr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_top #(.NUM_SRC(NS), .NUM_CH(NC)) dut (
    .clk(clk), .rst(rst), .srcReq(srcReq), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .chWrEn(chWrEn), .chWrSel(chWrSel), .chWrClaim(chWrClaim), .dtcDone(dtcDone),
    .dtcZeroCount(dtcZeroCount), .dtcIntSel(dtcIntSel), .cpuClr(cpuClr),
    .dmaReq(dmaReq), .dtcActValid(dtcActValid), .dtcActVec(dtcActVec),
    .cpuIrq(cpuIrq), .srcClr(srcClr)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeEn(input logic [NS-1:0] v);
    cfgWrEn = 1'b1; cfgWrData = v; tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic writeCh(input int ch, input logic [3:0] sel, input logic claim);
    chWrEn = '0; chWrEn[ch] = 1'b1; chWrSel = sel; chWrClaim = claim; tick();
    chWrEn = '0;
  endtask

  task automatic clearCpu();
    srcReq = '0; cpuClr = '1; tick();
    cpuClr = '0;
  endtask

  task automatic testReset();
    rst = 1'b1; tick(); tick();
    rst = 1'b0;
    chk("R1 valid", 32'(dtcActValid), 0);
    chk("R1 cpuIrq", 32'(cpuIrq), 0);
    chk("R1 srcClr", 32'(srcClr), 0);
    chk("R1 dmaReq", 32'(dmaReq), 0);
    srcReq = 16'h0008; tick();
    chk("R1 enable cleared -> cpu", 32'(cpuIrq), 32'h0008);
    chk("R1 enable cleared -> no dtc", 32'(dtcActValid), 0);
    clearCpu();
  endtask

  task automatic testCpuPath();
    writeEn(16'h0000);
    srcReq = 16'h0020; tick();
    chk("R4 cpu route", 32'(cpuIrq), 32'h0020);
    chk("R4 no dtc", 32'(dtcActValid), 0);
    srcReq = '0; tick();
    chk("R10 level held", 32'(cpuIrq), 32'h0020);
    srcReq = 16'h0020; cpuClr = 16'h0020; tick();
    chk("R10 set wins", 32'(cpuIrq), 32'h0020);
    srcReq = '0; tick();
    chk("R10 cleared", 32'(cpuIrq), 0);
    cpuClr = '0;
  endtask

  task automatic testDma();
    writeCh(0, 4'd7, 1'b0);
    writeCh(1, 4'd7, 1'b1);
    writeEn(16'h0080);
    srcReq = 16'h0080; #1;
    chk("R2 dma channel 1 only", 32'(dmaReq), 32'h2);
    tick();
    chk("R3 claimed no dtc", 32'(dtcActValid), 0);
    chk("R3 claimed no cpu", 32'(cpuIrq), 0);
    writeEn(16'h0000);
    tick();
    chk("R3 claimed enable0 no cpu", 32'(cpuIrq), 0);
    srcReq = '0; #1;
    chk("R2 dma drops with source", 32'(dmaReq), 0);
    writeCh(1, 4'd7, 1'b0);
    srcReq = 16'h0080; #1;
    chk("R2 unclaimed no dma", 32'(dmaReq), 0);
    tick();
    chk("R4 unclaimed back to cpu", 32'(cpuIrq), 32'h0080);
    clearCpu();
  endtask

  task automatic testPriority();
    writeEn(16'h1204);
    srcReq = 16'h1200; tick();
    chk("R6 lowest of 9,12", 32'(dtcActVec), 32'h0200);
    chk("R5 valid", 32'(dtcActValid), 1);
    srcReq = 16'h1204; tick();
    chk("R5 held while busy", 32'(dtcActVec), 32'h0200);
    dtcDone = 1'b1; tick();
    chk("R8 clr pulse", 32'(srcClr), 32'h0200);
    chk("R8 no cpu", 32'(cpuIrq), 0);
    chk("R5 released", 32'(dtcActValid), 0);
    dtcDone = 1'b0; srcReq = 16'h1004; tick();
    chk("R8 pulse one cycle", 32'(srcClr), 0);
    chk("R6 next lowest is 2", 32'(dtcActVec), 32'h0004);
    dtcDone = 1'b1; dtcIntSel = 1'b1; tick();
    chk("R7 intsel hands off", 32'(cpuIrq), 32'h0004);
    chk("R7 no clr pulse", 32'(srcClr), 0);
    dtcDone = 1'b0; dtcIntSel = 1'b0; tick();
    chk("R7 enable cleared, 12 next", 32'(dtcActVec), 32'h1000);
    dtcDone = 1'b1; dtcZeroCount = 1'b1; tick();
    chk("R7 zero count hands off", 32'(cpuIrq), 32'h1004);
    chk("R7 zero count no clr", 32'(srcClr), 0);
    dtcDone = 1'b0; dtcZeroCount = 1'b0;
    clearCpu(); tick();
    chk("R7 source now cpu only", 32'(dtcActValid), 0);
    srcReq = 16'h0200; tick();
    chk("R8 enable kept, regrant", 32'(dtcActVec), 32'h0200);
    dtcDone = 1'b1; tick();
    dtcDone = 1'b0; srcReq = '0; tick();
    chk("R8 idle after clear", 32'(dtcActValid), 0);
  endtask

  task automatic testOrder();
    writeEn(16'h0010);
    srcReq = 16'h0010; tick();
    chk("R9 dtc first", 32'(dtcActVec), 32'h0010);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 no cpu during transfer", 32'(cpuIrq), 0);
    end
    dtcDone = 1'b1; dtcIntSel = 1'b1; tick();
    chk("R9 cpu after transfer", 32'(cpuIrq), 32'h0010);
    dtcDone = 1'b0; dtcIntSel = 1'b0;
    clearCpu();
  endtask

  task automatic testEnableWrite();
    writeEn(16'h0100);
    srcReq = 16'h0101; tick();
    chk("R11 bit8 to dtc", 32'(dtcActVec), 32'h0100);
    chk("R11 bit0 to cpu", 32'(cpuIrq), 32'h0001);
    dtcDone = 1'b1; tick();
    dtcDone = 1'b0; srcReq = '0;
    clearCpu();
  endtask

  initial begin
    tick();
    testReset();
    testCpuPath();
    testDma();
    testPriority();
    testOrder();
    testEnableWrite();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule